// File: doc/BRIEF.md
# Conditional FP Move Condition Evaluator

This block decides whether a conditional floating-point move instruction carries out its move or behaves as a no-op. A 32-bit instruction word arrives with a valid strobe. The same cycle carries the floating-point status word with its four FP condition-code fields, the 32-bit and 64-bit integer condition-flag sets, and the value already read for the instruction's integer source register. One cycle later the block raises a done strobe together with a single execute bit. The execute bit is 1 for "perform the move" and 0 for "skip". The register file read and the data move itself sit outside the block.

Three condition sources are supported. The FP-code form picks one of four 2-bit FP condition codes and tests it against an eight-entry predicate table. The integer-flag form picks the 32-bit or the 64-bit flag set and tests it against a second eight-entry table. The register form compares a signed register value with zero. The FP-code and integer-flag forms share one invert bit. The register form has an invert bit of its own.

Top module: `fmov_cond_eval`

## Requirements
- R1: Only words whose bits 31:30 are 2'b10 and bits 24:19 are 6'h35 are evaluated. The form is then picked from bits 13:5. Bit 13 = 0 with bits 10:5 = 6'b000011 is the FP-code form. Bit 13 = 1, bit 11 = 0 and bits 10:5 = 6'b000011 is the integer-flag form. Bit 13 = 0 with bits 9:5 = 5'b00111 is the register form. Any other word gives execute = 0.
- R2: In the FP-code form, bits 12:11 select the code. A value of 0 reads status bits 11:10, 1 reads bits 33:32, 2 reads bits 35:34, and 3 reads bits 37:36. Code values are 0 equal, 1 less, 2 greater, 3 unordered.
- R3: The FP predicate is bits 16:14. Its values are: 0 never; 1 code is not 0; 2 code is 1 or 2; 3 code bit 0 is set; 4 code is 1; 5 code bit 1 is set; 6 code is 2; 7 code is 3.
- R4: Bit 17 inverts the predicate result in both the FP-code and the integer-flag forms.
- R5: In the integer-flag form, bit 12 picks the 64-bit flag set (1) or the 32-bit set (0). Each set is 4 bits, ordered N=bit 3, Z=bit 2, V=bit 1, C=bit 0.
- R6: The integer predicate is bits 16:14. Its values are: 0 never; 1 Z; 2 Z or (N xor V); 3 N xor V; 4 C or Z; 5 C; 6 N; 7 V.
- R7: The register predicate is bits 11:10. Its values are: 0 never; 1 value equals zero; 2 value is at most zero (signed); 3 value is below zero (signed). Bit 12 inverts the result.
- R8: The source register number is bits 18:14. Number 0 is treated as the value zero whatever the register value input carries.
- R9: After reset, done and execute are 0. Done is high exactly in the cycle after a valid input. Execute updates only on a valid input and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operands are present |
| insn_i | input | 32 | Instruction word |
| fsr_i | input | STATUS_W (64) | FP status word holding the four FP condition codes |
| icc_i | input | 4 | 32-bit integer flags {N,Z,V,C} |
| xcc_i | input | 4 | 64-bit integer flags {N,Z,V,C} |
| rs_val_i | input | REG_W (64) | Value of the integer source register |
| done_o | output | 1 | Result strobe, one cycle after valid_i |
| exec_o | output | 1 | 1 = perform the move, 0 = skip |

## Verification
The FP-code form is tried with a status word that holds a different code in each of the four fields. Every selector, predicate and invert setting is applied to it, so a swapped field position or a wrong table entry shows up. The integer-flag form is swept over all sixteen flag patterns in one set while the other set holds the complement. This separates the set selection from the predicate logic, including the N xor V terms. The register form uses zero, one, minus one and the two signed extremes, which separates the zero test from the sign test. Register number 0 is applied with a nonzero value present. Off-class and unrecognized words, and idle cycles with changing inputs, show that nothing outside a valid, recognized word moves the result.

// File: rtl/fmov_cond_pkg.sv
package fmov_cond_pkg;
  localparam int FCC_N   = 4;
  localparam int FCC_W   = 2;
  localparam int FLAG_W  = 4;
  localparam int FCC_LSB [FCC_N] = '{10, 32, 34, 36};

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FCC  = 2'd1,
    SRC_ICC  = 2'd2,
    SRC_REG  = 2'd3
  } cond_src_e;

  // flag bit positions within a 4-bit set
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;
endpackage

// File: rtl/fcc_eval.sv
module fcc_eval
  import fmov_cond_pkg::*;
#(
  parameter int STATUS_W = 64
) (
  input  logic [STATUS_W-1:0] fsr_i,
  input  logic [1:0]          sel_i,
  input  logic [2:0]          cond_i,
  output logic                hit_o
);
  logic [FCC_W-1:0] fields [FCC_N];
  logic [FCC_W-1:0] code;

  for (genvar g = 0; g < FCC_N; g++) begin : g_field
    assign fields[g] = fsr_i[FCC_LSB[g] +: FCC_W];
  end

  assign code = fields[sel_i];

  always_comb begin
    unique case (cond_i)
      3'd0: hit_o = 1'b0;
      3'd1: hit_o = (code != 2'd0);
      3'd2: hit_o = (code == 2'd1) || (code == 2'd2);
      3'd3: hit_o = code[0];
      3'd4: hit_o = (code == 2'd1);
      3'd5: hit_o = code[1];
      3'd6: hit_o = (code == 2'd2);
      default: hit_o = (code == 2'd3);
    endcase
  end
endmodule

// File: rtl/icc_eval.sv
module icc_eval
  import fmov_cond_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [2:0]        cond_i,
  output logic              hit_o
);
  logic n, z, v, c, lt;

  assign n  = flags_i[FLG_N];
  assign z  = flags_i[FLG_Z];
  assign v  = flags_i[FLG_V];
  assign c  = flags_i[FLG_C];
  assign lt = n ^ v;

  always_comb begin
    unique case (cond_i)
      3'd0: hit_o = 1'b0;
      3'd1: hit_o = z;
      3'd2: hit_o = z | lt;
      3'd3: hit_o = lt;
      3'd4: hit_o = c | z;
      3'd5: hit_o = c;
      3'd6: hit_o = n;
      default: hit_o = v;
    endcase
  end
endmodule

// File: rtl/rcond_eval.sv
module rcond_eval #(
  parameter int REG_W = 64,
  parameter int RNUM_W = 5
) (
  input  logic [REG_W-1:0]  val_i,
  input  logic [RNUM_W-1:0] rnum_i,
  input  logic [2:0]        rcond_i,
  output logic              hit_o
);
  logic [REG_W-1:0] val;
  logic is_zero, is_neg, raw;

  // register 0 is hardwired to zero
  assign val     = (rnum_i == '0) ? '0 : val_i;
  assign is_zero = (val == '0);
  assign is_neg  = val[REG_W-1];

  always_comb begin
    unique case (rcond_i[1:0])
      2'd0: raw = 1'b0;
      2'd1: raw = is_zero;
      2'd2: raw = is_zero | is_neg;
      default: raw = is_neg;
    endcase
  end

  assign hit_o = raw ^ rcond_i[2];
endmodule

// File: rtl/fmov_cond_eval.sv
module fmov_cond_eval
  import fmov_cond_pkg::*;
#(
  parameter int STATUS_W = 64,
  parameter int REG_W    = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [31:0]         insn_i,
  input  logic [STATUS_W-1:0] fsr_i,
  input  logic [FLAG_W-1:0]   icc_i,
  input  logic [FLAG_W-1:0]   xcc_i,
  input  logic [REG_W-1:0]    rs_val_i,
  output logic                done_o,
  output logic                exec_o
);
  localparam logic [1:0] OP_CLASS = 2'b10;
  localparam logic [5:0] OP3_FP2  = 6'h35;

  logic      class_ok;
  cond_src_e src;
  logic      fcc_hit, icc_hit, reg_hit, cc_inv, result;
  logic [FLAG_W-1:0] flags;

  assign class_ok = (insn_i[31:30] == OP_CLASS) && (insn_i[24:19] == OP3_FP2);

  always_comb begin
    src = SRC_NONE;
    if (class_ok) begin
      if (!insn_i[13] && insn_i[10:5] == 6'b000011)                     src = SRC_FCC;
      else if (insn_i[13] && !insn_i[11] && insn_i[10:5] == 6'b000011)  src = SRC_ICC;
      else if (!insn_i[13] && insn_i[9:5] == 5'b00111)                  src = SRC_REG;
    end
  end

  assign flags  = insn_i[12] ? xcc_i : icc_i;
  assign cc_inv = insn_i[17];

  fcc_eval #(.STATUS_W(STATUS_W)) u_fcc (
    .fsr_i (fsr_i),
    .sel_i (insn_i[12:11]),
    .cond_i(insn_i[16:14]),
    .hit_o (fcc_hit)
  );

  icc_eval u_icc (
    .flags_i(flags),
    .cond_i (insn_i[16:14]),
    .hit_o  (icc_hit)
  );

  rcond_eval #(.REG_W(REG_W), .RNUM_W(5)) u_reg (
    .val_i  (rs_val_i),
    .rnum_i (insn_i[18:14]),
    .rcond_i(insn_i[12:10]),
    .hit_o  (reg_hit)
  );

  always_comb begin
    unique case (src)
      SRC_FCC: result = fcc_hit ^ cc_inv;
      SRC_ICC: result = icc_hit ^ cc_inv;
      SRC_REG: result = reg_hit;
      default: result = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      exec_o <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) exec_o <= result;
    end
  end

  a_r9_done_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  a_r9_no_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  a_r9_exec_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(exec_o));
  a_r1_offclass_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !class_ok) |=> !exec_o);
  a_r3_never_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src == SRC_FCC && insn_i[17:14] == 4'd0) |=> !exec_o);
  a_r4_always_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src != SRC_NONE && src != SRC_REG && insn_i[17:14] == 4'd8) |=> exec_o);
  a_r8_reg0_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src == SRC_REG && insn_i[18:14] == 5'd0 && insn_i[12:10] == 3'd1) |=> exec_o);
endmodule

// File: tb/fmov_cond_eval_bench.sv
`timescale 1ns/1ps
module fmov_cond_eval_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] fsr = '0;
  logic [3:0]  icc = '0, xcc = '0;
  logic [63:0] rs_val = '0;
  logic        done, exec_r;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  fmov_cond_eval u_fmov_cond_eval (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn),
    .fsr_i(fsr), .icc_i(icc), .xcc_i(xcc), .rs_val_i(rs_val),
    .done_o(done), .exec_o(exec_r)
  );

  localparam logic [31:0] BASE = 32'h81a80000;

  function automatic logic [31:0] mk_fcc(input int sel, input int cond4);
    return BASE | (32'(cond4) << 14) | (32'(sel) << 11) | (32'h3 << 5);
  endfunction
  function automatic logic [31:0] mk_icc(input bit xsel, input int cond4);
    return BASE | (32'(cond4) << 14) | (32'h1 << 13) | (32'(xsel) << 12) | (32'h3 << 5);
  endfunction
  function automatic logic [31:0] mk_reg(input int rnum, input int rcond);
    return BASE | (32'(rnum) << 14) | (32'(rcond) << 10) | (32'h7 << 5);
  endfunction

  function automatic bit ref_fcc(input logic [1:0] c, input int p);
    case (p)
      0: return 0;
      1: return c == 1 || c == 2 || c == 3;
      2: return c == 1 || c == 2;
      3: return c == 1 || c == 3;
      4: return c == 1;
      5: return c == 2 || c == 3;
      6: return c == 2;
      default: return c == 3;
    endcase
  endfunction

  function automatic bit ref_icc(input logic [3:0] f, input int p);
    bit n = f[3], z = f[2], v = f[1], c = f[0];
    case (p)
      0: return 0;
      1: return z;
      2: return z || (n != v);
      3: return n != v;
      4: return c || z;
      5: return c;
      6: return n;
      default: return v;
    endcase
  endfunction

  function automatic bit ref_reg(input logic signed [63:0] x, input int p);
    case (p)
      1: return x == 0;
      2: return x <= 0;
      3: return x < 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive one valid word and check the result one cycle later
  task automatic apply(input logic [31:0] w, input logic exp, input string req);
    @(negedge clk);
    insn = w; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check({req, " done"}, done, 1'b1);
    check(req, exec_r, exp);
  endtask

  task automatic t_reset;
    check("R9 reset done", done, 1'b0);
    check("R9 reset exec", exec_r, 1'b0);
  endtask

  task automatic t_fcc;
    logic [1:0] codes [4] = '{2'd2, 2'd1, 2'd3, 2'd0};
    fsr = '0;
    fsr[11:10] = codes[0]; fsr[33:32] = codes[1];
    fsr[35:34] = codes[2]; fsr[37:36] = codes[3];
    fsr[9:8] = 2'd3; fsr[31:30] = 2'd1;  // neighbours must not leak
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 16; c++)
        apply(mk_fcc(s, c), ref_fcc(codes[s], c % 8) ^ (c >= 8), "R2 R3 R4 fcc");
  endtask

  task automatic t_icc;
    for (int f = 0; f < 16; f++)
      for (int c = 0; c < 16; c++) begin
        icc = 4'(f); xcc = ~4'(f);
        apply(mk_icc(1'b0, c), ref_icc(4'(f), c % 8) ^ (c >= 8), "R5 R6 R4 icc32");
        icc = ~4'(f); xcc = 4'(f);
        apply(mk_icc(1'b1, c), ref_icc(4'(f), c % 8) ^ (c >= 8), "R5 R6 R4 icc64");
      end
  endtask

  task automatic t_reg;
    logic [63:0] vals [5] = '{64'd0, 64'd1, 64'hffff_ffff_ffff_ffff,
                              64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0000};
    for (int i = 0; i < 5; i++)
      for (int r = 0; r < 8; r++) begin
        rs_val = vals[i];
        apply(mk_reg(9, r), ref_reg(vals[i], r % 4) ^ (r >= 4), "R7 reg");
      end
    rs_val = 64'h8000_0000_0000_0005;
    for (int r = 0; r < 8; r++)
      apply(mk_reg(0, r), ref_reg(64'd0, r % 4) ^ (r >= 4), "R8 reg0");
  endtask

  task automatic t_decode;
    fsr = '0; icc = 4'hf; xcc = 4'hf;
    apply(mk_fcc(0, 8), 1'b1, "R1 valid fcc always");
    apply(mk_fcc(0, 8) & ~32'h0008_0000, 1'b0, "R1 wrong op3");
    apply(mk_fcc(0, 8) & ~32'h8000_0000, 1'b0, "R1 wrong class");
    apply(mk_fcc(0, 8) | (32'h1 << 9), 1'b0, "R1 unknown opf");
    apply(mk_icc(1'b0, 8) | (32'h1 << 11), 1'b0, "R1 icc bit11 set");
  endtask

  task automatic t_hold;
    apply(mk_fcc(0, 8), 1'b1, "R9 prime");
    @(negedge clk);
    insn = mk_fcc(0, 0); rs_val = '1; fsr = '1;
    @(negedge clk);
    check("R9 idle done", done, 1'b0);
    check("R9 idle hold", exec_r, 1'b1);
    apply(mk_fcc(0, 0), 1'b0, "R9 next valid");
    @(negedge clk);
    check("R9 hold low", exec_r, 1'b0);
  endtask

  initial begin
    #200000ns;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1 t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fcc();
    t_icc();
    t_reg();
    t_decode();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule